// File: doc/BRIEF.md
# Compare-Reset Interval Timer

This block is a 16-bit up-counter that advances on qualified tick cycles and sets a sticky overflow flag when it wraps. The flag, gated by an enable input, drives an interrupt line. Software can overwrite either byte of the counter through byte-enabled writes.

Two compare channels watch the counter. Each has its own compare value and a 4-bit mode field. When a channel's mode selects the special-event code and the counter equals its compare value on a tick cycle, the counter returns to zero instead of stepping. The compare value then sets the count period, and a reset of this kind never raises the overflow flag. A special event on the second channel also produces a one-cycle converter start pulse, but only while the converter-enable input is high. The block covers synchronous operation only.

Top module: `cmp_timer16`

## Requirements
- R1: Reset clears the counter to 0x0000, the flag and the start pulse. On an edge where `tick_i` is high and no write or special event is active, the counter gains exactly one. With `tick_i` low and no write, it keeps its value.
- R2: A tick at 0x FFFF with no write and no special event makes the counter 0x0000 and sets `ovf_flag_o` at the same edge.
- R3: `ovf_flag_o` stays high until an edge with `flag_clr_i` high. If a wrap and a clear occur at the same edge, the flag ends up set.
- R4: `irq_o` is `ovf_flag_o` AND `irq_en_i`, with no added delay.
- R5: `wr_be_i[0]` loads `wr_data_i[7:0]` into counter bits 7:0 and `wr_be_i[1]` loads `wr_data_i[15:8]` into bits 15:8. A byte that is not enabled keeps its value. Any write overrides the tick step, so a write together with a tick at 0xFFFF does not set the flag.
- R6: Channel n uses `cmp_val_i[16n+15:16n]` and `cmp_mode_i[4n+3:4n]`. When the mode is 4'b1011, the counter equals the compare value and `tick_i` is high, the next counter value is 0x0000. The compare uses the value held before the step, so the period is the compare value plus one ticks. Other mode codes never reset the counter.
- R7: A special-event reset never sets `ovf_flag_o`, even when the compare value is 0xFFFF.
- R8: When a write coincides with a special event, the written value is loaded and the reset has no effect.
- R9: A special event on channel 1 while `adc_en_i` is high drives `adc_start_o` high for the one cycle after that edge. No pulse occurs for channel 0 events, when `adc_en_i` is low, or while a matching counter is not ticking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count qualifier (enable or prescaled tick) |
| wr_be_i | input | 2 | Byte enables for a counter write |
| wr_data_i | input | 16 | Counter write data |
| flag_clr_i | input | 1 | Clears the overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_val_i | input | 32 | Compare values, channel n at bits 16n+15:16n |
| cmp_mode_i | input | 8 | Mode fields, channel n at bits 4n+3:4n |
| adc_en_i | input | 1 | Allows the converter start pulse |
| count_o | output | 16 | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| adc_start_o | output | 1 | One-cycle converter start pulse |

## Verification
The counter, the flag and the start pulse are all registered. Each one changes at the first rising edge that samples the stimulus and is valid from that edge until the next. `irq_o` follows the flag and the enable input in the same cycle. The bench drives inputs on falling edges and steps its reference model at each rising edge. It compares all four outputs one nanosecond after that edge, when both the model and the design hold their new state and the inputs are still stable.

// File: rtl/ctimer_pkg.sv
`timescale 1ns/1ps
package ctimer_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [3:0] SPECIAL_EVT_CODE = 4'b1011;
endpackage

// File: rtl/ctimer_cmp_chan.sv
`timescale 1ns/1ps
module ctimer_cmp_chan #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned MODE_W = 4,
   parameter logic [MODE_W-1:0] EVT_CODE = '1
) (
   input  logic [CNT_W-1:0]  count_i,
   input  logic [CNT_W-1:0]  cmp_val_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              tick_i,
   output logic              evt_o
);
   logic mode_hit;
   logic val_hit;

   always_comb begin
      mode_hit = (mode_i == EVT_CODE);
      val_hit  = (count_i == cmp_val_i);
      evt_o    = tick_i & mode_hit & val_hit;
   end
endmodule

// File: rtl/ctimer_counter.sv
`timescale 1ns/1ps
module ctimer_counter
   import ctimer_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   localparam int unsigned NB = CNT_W / BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic [NB-1:0]    wr_be_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wr_val;
   logic             any_wr;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign wr_val[b*BYTE_W +: BYTE_W] = wr_be_i[b] ? wr_data_i[b*BYTE_W +: BYTE_W]
                                                     : cnt_q[b*BYTE_W +: BYTE_W];
   end

   assign any_wr = |wr_be_i;
   assign wrap_o = tick_i & ~any_wr & ~trig_i & (cnt_q == CNT_MAX);
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (any_wr) begin
         cnt_q <= wr_val;
      end else if (trig_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !any_wr) |=> $stable(cnt_q));
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !trig_i && !any_wr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !trig_i && !any_wr && cnt_q == CNT_MAX) |=> (cnt_q == '0));
   assert_trig_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !any_wr) |=> (cnt_q == '0));
   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && (&wr_be_i)) |=> (cnt_q == $past(wr_data_i)));
endmodule

// File: rtl/ctimer_ovf_flag.sv
`timescale 1ns/1ps
module ctimer_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/cmp_timer16.sv
`timescale 1ns/1ps
module cmp_timer16
   import ctimer_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MODE_W  = 4,
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned ADC_CH  = 1,
   parameter logic [MODE_W-1:0] EVT_CODE = MODE_W'(SPECIAL_EVT_CODE),
   localparam int unsigned NB = CNT_W / BYTE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_i,
   input  logic [NB-1:0]            wr_be_i,
   input  logic [CNT_W-1:0]         wr_data_i,
   input  logic                     flag_clr_i,
   input  logic                     irq_en_i,
   input  logic [NUM_CH*CNT_W-1:0]  cmp_val_i,
   input  logic [NUM_CH*MODE_W-1:0] cmp_mode_i,
   input  logic                     adc_en_i,
   output logic [CNT_W-1:0]         count_o,
   output logic                     ovf_flag_o,
   output logic                     irq_o,
   output logic                     adc_start_o
);
   if (CNT_W % BYTE_W != 0 || CNT_W == 0) begin : g_bad_width
      $error("cmp_timer16: CNT_W must be a non-zero multiple of the byte width");
   end
   if (NUM_CH == 0 || ADC_CH >= NUM_CH) begin : g_bad_chan
      $error("cmp_timer16: ADC_CH must name an existing channel");
   end

   logic [CNT_W-1:0]  cnt;
   logic [NUM_CH-1:0] evt;
   logic              evt_any;
   logic              wrap;
   logic              adc_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      ctimer_cmp_chan #(
         .CNT_W   (CNT_W),
         .MODE_W  (MODE_W),
         .EVT_CODE(EVT_CODE)
      ) u_chan (
         .count_i  (cnt),
         .cmp_val_i(cmp_val_i[c*CNT_W +: CNT_W]),
         .mode_i   (cmp_mode_i[c*MODE_W +: MODE_W]),
         .tick_i   (tick_i),
         .evt_o    (evt[c])
      );
   end

   assign evt_any = |evt;

   ctimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .trig_i   (evt_any),
      .wr_be_i  (wr_be_i),
      .wr_data_i(wr_data_i),
      .count_o  (cnt),
      .wrap_o   (wrap)
   );

   ctimer_ovf_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wrap),
      .clr_i (flag_clr_i),
      .flag_o(ovf_flag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adc_q <= 1'b0;
      end else begin
         adc_q <= evt[ADC_CH] & adc_en_i;
      end
   end

   assign count_o     = cnt;
   assign irq_o       = ovf_flag_o & irq_en_i;
   assign adc_start_o = adc_q;

   assert_no_flag_on_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag_o && evt_any && !flag_clr_i) |=> !ovf_flag_o);
   assert_adc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |-> ($past(adc_en_i) && $past(tick_i)));
   assert_adc_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[ADC_CH]) |=> !adc_start_o);
endmodule

// File: tb/cmp_timer16_test.sv
`timescale 1ns/1ps
module cmp_timer16_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_i;
   logic [1:0]  wr_be_i;
   logic [15:0] wr_data_i;
   logic        flag_clr_i;
   logic        irq_en_i;
   logic [31:0] cmp_val_i;
   logic [7:0]  cmp_mode_i;
   logic        adc_en_i;
   logic [15:0] count_o;
   logic        ovf_flag_o;
   logic        irq_o;
   logic        adc_start_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference state
   int m_cnt  = 0;
   bit m_flag = 1'b0;
   bit m_adc  = 1'b0;

   cmp_timer16 uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_be_i(wr_be_i),
      .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
      .cmp_val_i(cmp_val_i), .cmp_mode_i(cmp_mode_i), .adc_en_i(adc_en_i),
      .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
      .adc_start_o(adc_start_o)
   );

   always #2.5 clk = ~clk;

   // behavioural model, stepped at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_flag = 1'b0; m_adc = 1'b0;
      end else begin
         bit e0, e1, trig, wrap;
         int nxt;
         e0 = tick_i && cmp_mode_i[3:0] == 4'hB && m_cnt == int'(cmp_val_i[15:0]);
         e1 = tick_i && cmp_mode_i[7:4] == 4'hB && m_cnt == int'(cmp_val_i[31:16]);
         trig = e0 || e1;
         wrap = 1'b0;
         nxt = m_cnt;
         if (wr_be_i != 2'b00) begin
            if (wr_be_i[0]) nxt = (nxt / 256) * 256 + int'(wr_data_i[7:0]);
            if (wr_be_i[1]) nxt = int'(wr_data_i[15:8]) * 256 + (nxt % 256);
         end else if (trig) begin
            nxt = 0;
         end else if (tick_i) begin
            if (m_cnt == 65535) begin nxt = 0; wrap = 1'b1; end
            else nxt = m_cnt + 1;
         end
         m_cnt = nxt;
         if (wrap) m_flag = 1'b1;
         else if (flag_clr_i) m_flag = 1'b0;
         m_adc = e1 && adc_en_i;
      end
   end

   task automatic chk(string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %h exp %h at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   always begin
      @(posedge clk);
      #1;
      if (!done) begin
         chk("count", int'(count_o), m_cnt);
         chk("flag", int'(ovf_flag_o), int'(m_flag));
         chk("irq", int'(irq_o), int'(m_flag && irq_en_i));
         chk("adc_start", int'(adc_start_o), int'(m_adc));
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(logic [15:0] v);
      wr_be_i = 2'b11; wr_data_i = v; cyc(1); wr_be_i = 2'b00;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick_i = 0; wr_be_i = 0; wr_data_i = 0; flag_clr_i = 0;
      irq_en_i = 0; cmp_val_i = 0; cmp_mode_i = 0; adc_en_i = 0;
      cur_req = "R1";
      cyc(3); rst_n = 1'b1;
      tick_i = 1; cyc(5); tick_i = 0; cyc(3);
      for (int i = 0; i < 10; i++) begin tick_i = i[0]; cyc(1); end
      tick_i = 0;

      cur_req = "R5";
      wr_be_i = 2'b01; wr_data_i = 16'hEEA5; tick_i = 1; cyc(1);
      wr_be_i = 2'b10; wr_data_i = 16'h3477; cyc(1);
      wr_be_i = 2'b00; tick_i = 0; cyc(2);
      load(16'hFFFF);
      wr_be_i = 2'b11; wr_data_i = 16'hFFFF; tick_i = 1; cyc(1);
      wr_be_i = 2'b00; tick_i = 0; cyc(2);

      cur_req = "R2";
      load(16'hFFFD);
      tick_i = 1; cyc(4); tick_i = 0; cyc(2);

      cur_req = "R4";
      irq_en_i = 1; cyc(2); irq_en_i = 0; cyc(1); irq_en_i = 1; cyc(1);

      cur_req = "R3";
      flag_clr_i = 1; cyc(1); flag_clr_i = 0; cyc(2);
      load(16'hFFFF);
      tick_i = 1; flag_clr_i = 1; cyc(1);
      tick_i = 0; flag_clr_i = 0; cyc(3);
      flag_clr_i = 1; cyc(1); flag_clr_i = 0; cyc(1);

      cur_req = "R6";
      cmp_val_i[15:0] = 16'd5; cmp_mode_i[3:0] = 4'b1011;
      load(16'h0000);
      tick_i = 1; cyc(20);
      cmp_mode_i[3:0] = 4'b1010; cyc(10);
      tick_i = 0; cyc(1);

      cur_req = "R7";
      cmp_val_i[15:0] = 16'hFFFF; cmp_mode_i[3:0] = 4'b1011;
      load(16'hFFF8);
      tick_i = 1; cyc(12); tick_i = 0; cyc(2);

      cur_req = "R8";
      cmp_val_i[15:0] = 16'h0020;
      load(16'h0020);
      tick_i = 1; wr_be_i = 2'b11; wr_data_i = 16'h1234; cyc(1);
      wr_be_i = 2'b00; tick_i = 0; cyc(2);

      cur_req = "R9";
      cmp_mode_i[3:0] = 4'h0;
      cmp_val_i[31:16] = 16'd3; cmp_mode_i[7:4] = 4'b1011; adc_en_i = 1;
      load(16'h0000);
      tick_i = 1; cyc(10);
      adc_en_i = 0; cyc(10);
      adc_en_i = 1; load(16'h0003); tick_i = 0; cyc(4);
      cmp_mode_i[7:4] = 4'h0; cmp_val_i[15:0] = 16'd3; cmp_mode_i[3:0] = 4'b1011;
      load(16'h0000);
      tick_i = 1; cyc(10); tick_i = 0; cyc(2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule